// File: doc/BRIEF.md
# Indirect-Indexed Bus Cycle Sequencer

This block reproduces, cycle by cycle, the bus traffic an 8-bit processor makes when it executes a load or store through a zero-page pointer plus the Y index. After a one-cycle start strobe it captures the program counter, Y and the accumulator. It then fetches the opcode and the pointer byte, and reads the two-byte base address from page zero. The pointer's second byte wraps within page zero. The block then carries out the access at base plus Y.

Adding Y to the base low byte can carry into the high byte. In that case the first access reaches an address one page below the real target, because the high byte has not yet been fixed. A store always spends a cycle on this partial address as a discarded read and writes in the following cycle. A load spends the extra cycle only when the addition carries. Every discarded read is marked on a dummy tag so that a bus monitor or a trace filter can tell real accesses from incidental ones. Memory sits outside the block and answers on the read-data input in the same cycle.

Top module: `ind_idx_seq`

## Requirements
- R1: While the active-low synchronous reset `rstN` is low, and on the first cycle after it, the block is idle: `busRnW` is 1, `dummyTag` is 0, `done` is 0 and `busAddr` is 0. A reset in the middle of a transaction abandons it.
- R2: The first bus cycle after the start strobe reads at the captured PC (the opcode). The second reads at PC+1 (the pointer byte). Both cycles have `dummyTag` at 0.
- R3: The third cycle reads at address {8'h00, pointer}. The fourth reads at {8'h00, (pointer+1) mod 256}, so the pointer's second byte never leaves page zero. Both cycles have `dummyTag` at 0.
- R4: For a store (`isStore`=1), the fifth cycle is always a read at {base high, (base low + Y) mod 256} with `dummyTag` at 1, whether or not the addition carries.
- R5: For a store, the sixth cycle writes the captured accumulator with `busRnW`=0 and `dummyTag`=0. The write goes to ({base high, base low} + Y) mod 65536.
- R6: For a load (`isStore`=0) with no carry out of base low + Y, the fifth cycle is the real read at base + Y with `dummyTag` at 0, and the transaction has only five bus cycles.
- R7: For a load whose low-byte addition carries, the fifth cycle is a dummy read at the partial address (high byte uncorrected, `dummyTag`=1). The sixth cycle is the real read at the corrected address (high byte plus one, same low byte, `dummyTag`=0).
- R8: `done` is high for exactly one cycle, the one right after the final bus cycle, and the bus is idle in that cycle. During that cycle a load presents on `loadData` the byte that was read in its final bus cycle.
- R9: A start strobe that arrives while a transaction is in progress, including its `done` cycle, is ignored. The running sequence is unchanged, and no new transaction begins after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| isStore | input | 1 | 1 = store form, 0 = load form; captured at start |
| pcStart | input | 16 | Address of the opcode; captured at start |
| regY | input | 8 | Index register value; captured at start |
| accVal | input | 8 | Accumulator value to store; captured at start |
| rdData | input | 8 | Memory read data for the current bus address |
| busAddr | output | 16 | Bus address of the current cycle |
| busRnW | output | 1 | 1 = read cycle, 0 = write cycle |
| busWdata | output | 8 | Write data, valid when busRnW is 0 |
| dummyTag | output | 1 | Current bus cycle's data is discarded |
| loadData | output | 8 | Value fetched by a load, valid with done |
| done | output | 1 | One-cycle pulse after the final bus cycle |

## Verification
The embedded properties check on every cycle that the pointer-byte reads stay in page zero, that a tagged cycle is always a read, and that the cycle after a tagged read keeps the same low byte. When that next cycle is a read, they also check that its high byte has gone up by one. They further check that a write is never tagged and always follows a tagged read, that `done` lasts one cycle, and that no new sequence starts while one is running. The bench scenarios are what show the actual address values, the accumulator on the write, the choice between five and six cycles for loads, the zero-page wrap of a pointer of $FF, the 16-bit wrap of the target, the returned load byte, and recovery from a reset mid-transaction.

// File: rtl/ind_idx_pkg.sv
package ind_idx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_PTR,
    ST_LO,
    ST_HI,
    ST_PART,
    ST_FINAL,
    ST_DONE
  } seqState_t;

  typedef enum logic [2:0] {
    ADR_NONE,
    ADR_PC,
    ADR_ZP,
    ADR_ZP1,
    ADR_PART,
    ADR_FULL
  } addrSel_t;

  typedef struct packed {
    logic     latchArgs;
    logic     incPc;
    logic     capPtr;
    logic     capLo;
    logic     capHi;
    logic     capResult;
    addrSel_t addrSel;
    logic     readCycle;
    logic     dummy;
  } dpStrobe_t;

endpackage

// File: rtl/ind_idx_ctrl.sv
module ind_idx_ctrl
  import ind_idx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       isStore,
  input  logic       carry,
  output dpStrobe_t  strobe,
  output logic       done,
  output seqState_t  stateQ
);

  seqState_t stateD;
  logic      opStoreQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      opStoreQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE && start) opStoreQ <= isStore;
    end
  end

  always_comb begin
    stateD           = stateQ;
    strobe           = '0;
    strobe.addrSel   = ADR_NONE;
    strobe.readCycle = 1'b1;
    done             = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.latchArgs = 1'b1;
          stateD           = ST_OPC;
        end
      end
      ST_OPC: begin
        strobe.addrSel = ADR_PC;
        strobe.incPc   = 1'b1;
        stateD         = ST_PTR;
      end
      ST_PTR: begin
        strobe.addrSel = ADR_PC;
        strobe.incPc   = 1'b1;
        strobe.capPtr  = 1'b1;
        stateD         = ST_LO;
      end
      ST_LO: begin
        strobe.addrSel = ADR_ZP;
        strobe.capLo   = 1'b1;
        stateD         = ST_HI;
      end
      ST_HI: begin
        strobe.addrSel = ADR_ZP1;
        strobe.capHi   = 1'b1;
        stateD         = ST_PART;
      end
      ST_PART: begin
        strobe.addrSel = ADR_PART;
        if (opStoreQ || carry) begin
          strobe.dummy = 1'b1;
          stateD       = ST_FINAL;
        end else begin
          strobe.capResult = 1'b1;
          stateD           = ST_DONE;
        end
      end
      ST_FINAL: begin
        strobe.addrSel = ADR_FULL;
        if (opStoreQ) strobe.readCycle = 1'b0;
        else          strobe.capResult = 1'b1;
        stateD = ST_DONE;
      end
      ST_DONE: begin
        done   = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: once busy, no new sequence begins before returning to idle
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE) |=> (stateQ != ST_OPC));

  // R6/R7: a load decides its length from the carry only in the partial cycle
  assert_load_short_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PART && !opStoreQ && !carry) |=> (stateQ == ST_DONE));

endmodule

// File: rtl/ind_idx_datapath.sv
module ind_idx_datapath
  import ind_idx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] pcStart,
  input  logic [DATA_W-1:0] regY,
  input  logic [DATA_W-1:0] accVal,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRnW,
  output logic [DATA_W-1:0] busWdata,
  output logic              dummyTag,
  output logic [DATA_W-1:0] loadData,
  output logic              carry
);

  logic [ADDR_W-1:0] pcQ;
  logic [DATA_W-1:0] yQ, accQ, ptrQ, loQ, hiQ, sumQ;
  logic              carryQ;
  logic [DATA_W:0]   lowSum;
  logic [DATA_W-1:0] ptrNext, hiFixed;

  assign lowSum  = {1'b0, loQ} + {1'b0, yQ};
  assign ptrNext = ptrQ + DATA_W'(1);
  assign hiFixed = hiQ + DATA_W'(carryQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ      <= '0;
      yQ       <= '0;
      accQ     <= '0;
      ptrQ     <= '0;
      loQ      <= '0;
      hiQ      <= '0;
      sumQ     <= '0;
      carryQ   <= 1'b0;
      loadData <= '0;
    end else begin
      if (strobe.latchArgs) begin
        pcQ  <= pcStart;
        yQ   <= regY;
        accQ <= accVal;
      end
      if (strobe.incPc)     pcQ  <= pcQ + ADDR_W'(1);
      if (strobe.capPtr)    ptrQ <= rdData;
      if (strobe.capLo)     loQ  <= rdData;
      if (strobe.capHi) begin
        hiQ    <= rdData;
        sumQ   <= lowSum[DATA_W-1:0];
        carryQ <= lowSum[DATA_W];
      end
      if (strobe.capResult) loadData <= rdData;
    end
  end

  always_comb begin
    unique case (strobe.addrSel)
      ADR_PC:   busAddr = pcQ;
      ADR_ZP:   busAddr = {{DATA_W{1'b0}}, ptrQ};
      ADR_ZP1:  busAddr = {{DATA_W{1'b0}}, ptrNext};
      ADR_PART: busAddr = {hiQ, sumQ};
      ADR_FULL: busAddr = {hiFixed, sumQ};
      default:  busAddr = '0;
    endcase
  end

  assign busRnW   = strobe.readCycle;
  assign busWdata = strobe.readCycle ? '0 : accQ;
  assign dummyTag = strobe.dummy;
  assign carry    = carryQ;

  // R5: write data is the accumulator captured at start
  assert_wdata_acc_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busRnW |-> (busWdata == accQ));

endmodule

// File: rtl/ind_idx_seq.sv
module ind_idx_seq
  import ind_idx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isStore,
  input  logic [ADDR_W-1:0] pcStart,
  input  logic [DATA_W-1:0] regY,
  input  logic [DATA_W-1:0] accVal,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRnW,
  output logic [DATA_W-1:0] busWdata,
  output logic              dummyTag,
  output logic [DATA_W-1:0] loadData,
  output logic              done
);

  dpStrobe_t strobe;
  seqState_t stateQ;
  logic      carry;

  ind_idx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .isStore (isStore),
    .carry   (carry),
    .strobe  (strobe),
    .done    (done),
    .stateQ  (stateQ)
  );

  ind_idx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pcStart  (pcStart),
    .regY     (regY),
    .accVal   (accVal),
    .rdData   (rdData),
    .busAddr  (busAddr),
    .busRnW   (busRnW),
    .busWdata (busWdata),
    .dummyTag (dummyTag),
    .loadData (loadData),
    .carry    (carry)
  );

  // R3: both pointer-byte reads stay inside page zero
  assert_zp_page_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LO || stateQ == ST_HI) |-> (busAddr[ADDR_W-1:DATA_W] == '0));

  // R4: a tagged cycle is always a read
  assert_dummy_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    dummyTag |-> busRnW);

  // R4/R7: the cycle after a dummy read keeps the adjusted low byte
  assert_dummy_low_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    dummyTag |=> (busAddr[DATA_W-1:0] == $past(busAddr[DATA_W-1:0])));

  // R7: a load's corrected read raises the high byte by one page
  assert_fix_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dummyTag ##1 (busRnW && !done)) |->
      ((busAddr[ADDR_W-1:DATA_W] - $past(busAddr[ADDR_W-1:DATA_W])) == DATA_W'(1)));

  // R5: a write is never tagged and always follows the dummy read
  assert_write_real_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busRnW |-> (!dummyTag && $past(dummyTag)));

endmodule

// File: tb/ind_idx_seq_bench.sv
`timescale 1ns/1ps
module ind_idx_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isStore = 1'b0;
  logic [15:0] pcStart = '0;
  logic [7:0]  regY = '0;
  logic [7:0]  accVal = '0;
  logic [7:0]  rdData;
  logic [15:0] busAddr;
  logic        busRnW;
  logic [7:0]  busWdata;
  logic        dummyTag;
  logic [7:0]  loadData;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [15:0] curPc;
  logic [7:0]  curPtr, curLo, curHi;

  always #2 clk = ~clk;

  ind_idx_seq u_ind_idx_seq (
    .clk(clk), .rstN(rstN), .start(start), .isStore(isStore),
    .pcStart(pcStart), .regY(regY), .accVal(accVal), .rdData(rdData),
    .busAddr(busAddr), .busRnW(busRnW), .busWdata(busWdata),
    .dummyTag(dummyTag), .loadData(loadData), .done(done)
  );

  function automatic logic [7:0] memFn(input logic [15:0] a);
    if (a == curPc)                          return 8'h91;
    if (a == curPc + 16'd1)                  return curPtr;
    if (a == {8'h00, curPtr})                return curLo;
    if (a == {8'h00, curPtr + 8'd1})         return curHi;
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_comb rdData = memFn(busAddr);

  // isStore, pc, ptr, lo, hi, y, acc
  localparam int NV = 7;
  localparam logic [56:0] VECS [NV] = '{
    {1'b1, 16'h1000, 8'hFC, 8'h00, 8'h04, 8'h23, 8'h04},
    {1'b1, 16'h2000, 8'h10, 8'hF0, 8'h12, 8'h20, 8'hAA},
    {1'b0, 16'h3000, 8'h40, 8'h10, 8'h05, 8'h05, 8'h00},
    {1'b0, 16'h3456, 8'h80, 8'hFF, 8'h07, 8'h01, 8'h00},
    {1'b0, 16'h4000, 8'hFF, 8'h80, 8'h22, 8'h7F, 8'h00},
    {1'b1, 16'h5000, 8'hFF, 8'hC0, 8'hFF, 8'h50, 8'h3C},
    {1'b0, 16'h6000, 8'h20, 8'h00, 8'h80, 8'h00, 8'h00}
  };

  task automatic check(input string req, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkBus(input string req, input logic [15:0] eAddr,
                          input bit eRnW, input bit eDummy, input logic [7:0] eWd);
    check(req, busAddr == eAddr && busRnW == eRnW && dummyTag == eDummy &&
               (eRnW || busWdata == eWd), "addr/rnw/dummy/wdata",
          {busAddr, 6'd0, busRnW, dummyTag, busWdata}, {eAddr, 6'd0, eRnW, eDummy, eWd});
  endtask

  task automatic runVec(input int idx, input bit midStart);
    logic [56:0] v;
    bit st; logic [15:0] pc, part, full; logic [7:0] ptr, lo, hi, y, acc;
    logic [8:0] ls; bit cy; int n;
    v = VECS[idx];
    {st, pc, ptr, lo, hi, y, acc} = v;
    curPc = pc; curPtr = ptr; curLo = lo; curHi = hi;
    ls   = {1'b0, lo} + {1'b0, y};
    cy   = ls[8];
    part = {hi, ls[7:0]};
    full = {hi, lo} + {8'h00, y};
    n    = (st || cy) ? 6 : 5;
    isStore = st; pcStart = pc; regY = y; accVal = acc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= n; k++) begin
      case (k)
        1: checkBus("R2", pc, 1, 0, 8'h00);
        2: checkBus("R2", pc + 16'd1, 1, 0, 8'h00);
        3: checkBus("R3", {8'h00, ptr}, 1, 0, 8'h00);
        4: checkBus("R3", {8'h00, ptr + 8'd1}, 1, 0, 8'h00);
        5: if (st)      checkBus("R4", part, 1, 1, 8'h00);
           else if (cy) checkBus("R7", part, 1, 1, 8'h00);
           else         checkBus("R6", full, 1, 0, 8'h00);
        default: if (st) checkBus("R5", full, 0, 0, acc);
                 else    checkBus("R7", full, 1, 0, 8'h00);
      endcase
      if (midStart && k == 3) begin start = 1'b1; isStore = !st; pcStart = 16'h0BAD; end
      if (midStart && k == n) start = 1'b1;
      @(negedge clk);
      if (midStart && k == 3) begin isStore = st; pcStart = pc; start = 1'b0; end
    end
    check("R8", done == 1'b1 && busRnW && !dummyTag, "done cycle", {29'd0, done, busRnW, dummyTag}, 32'h6);
    if (!st) check("R8", loadData == memFn(full), "loadData", {24'd0, loadData}, {24'd0, memFn(full)});
    start = 1'b0;
    @(negedge clk);
    check(midStart ? "R9" : "R8", !done && busRnW && !dummyTag && busAddr == 16'h0000,
          "idle after done", {busAddr, 13'd0, done, busRnW, dummyTag}, 32'h0000_0002);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    curPc = 16'hFFF0; curPtr = 8'h00; curLo = 8'h00; curHi = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", busRnW && !dummyTag && !done && busAddr == 16'h0000, "reset state",
          {busAddr, 13'd0, done, busRnW, dummyTag}, 32'h2);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", busRnW && !dummyTag && !done, "idle after reset",
          {29'd0, done, busRnW, dummyTag}, 32'h2);

    for (int i = 0; i < NV; i++) runVec(i, 1'b0);

    // R9: new start strobes during a busy transaction
    runVec(3, 1'b1);
    runVec(1, 1'b1);

    // R1: reset in the middle of a transaction
    isStore = 1'b1; pcStart = 16'h2000; regY = 8'h20; accVal = 8'hAA;
    curPc = 16'h2000; curPtr = 8'h10; curLo = 8'hF0; curHi = 8'h12;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", busRnW && !dummyTag && !done && busAddr == 16'h0000, "mid reset",
          {busAddr, 13'd0, done, busRnW, dummyTag}, 32'h2);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", busRnW && !dummyTag && !done && busAddr == 16'h0000, "stays idle",
          {busAddr, 13'd0, done, busRnW, dummyTag}, 32'h2);
    runVec(0, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule